// File: doc/BRIEF.md
# ADC Result Byte Output Controller

This block takes the latched result of an analog-to-digital conversion (a 12-bit magnitude with a polarity flag and an overrange flag) and places it on an 8-bit data path in one of two ways. In direct mode a host reads either half of the result at any time. It does this by raising a chip enable together with a low-byte or high-byte enable. The block reports through a drive-enable output when the bus should carry its data. Bus tri-stating is left to the surrounding logic.

In handshake mode the block pushes the result to an external serial transmitter as two bytes, low byte first. Each byte goes out only after the transmitter raises its send request. The block moves on only after the transmitter acknowledges the byte with a take strobe. A single mode input selects the behaviour. A rising edge on it starts one transfer of the current result, after which the block falls back to direct mode by itself. While the input stays high, every end-of-conversion strobe starts a further transfer. Each transfer works from a copy of the result captured when the transfer starts.

Top module: `adc_byte_out`

## Requirements
- R1: After reset, `hs_busy_o`, `hs_valid_o` and `bus_drive_o` are 0 and `data_o` is 0.
- R2: In direct mode (`hs_busy_o`=0), with `chip_en_i`=1 and `lo_en_i`=1, `data_o` equals magnitude bits 7:0 and `bus_drive_o`=1 in the same cycle.
- R3: In direct mode, with `chip_en_i`=1, `hi_en_i`=1 and `lo_en_i`=0, `data_o` carries magnitude bits 11:8 in bits 3:0, overrange in bit 4, polarity in bit 5, and zero in bits 7:6. When both byte enables are high, the low byte wins.
- R4: With `chip_en_i`=0, or with neither byte enable high, `bus_drive_o`=0 and `data_o`=0 while no handshake byte is presented.
- R5: While direct mode is in effect and no start occurs, `send_i` and `take_i` have no effect: `hs_busy_o` and `hs_valid_o` stay 0.
- R6: A rising edge on `mode_i` sampled while idle starts a transfer: `hs_busy_o` is 1 after that clock edge. The result captured at that edge is the one sent.
- R7: A byte is presented (`hs_valid_o`=1) only in the cycle after `send_i` is sampled high while waiting for it. It is never presented before that.
- R8: Bytes go out low first, then high, using the R2/R3 layouts. A presented byte stays on `data_o` with `hs_valid_o`=1 until `take_i` is sampled high, and only then does the block advance.
- R9: After the high byte is taken, `hs_busy_o` returns to 0 at the next edge.
- R10: With `mode_i` held high and the block idle, an `eoc_i` pulse starts a new transfer of the result at that edge. With `mode_i` low, `eoc_i` starts nothing.
- R11: Changes on `mag_i`, `pol_i` and `ovr_i` during a transfer do not alter the bytes sent.
- R12: A `mode_i` rising edge or an `eoc_i` pulse during a transfer is ignored. Once both bytes are taken, the block is idle, with no transfer queued.
- R13: While a transfer is active, direct reads are disabled: `bus_drive_o`=0 regardless of the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Output mode select / one-shot trigger |
| eoc_i | input | 1 | End-of-conversion strobe, one cycle |
| mag_i | input | MAG_W | Latched conversion magnitude |
| pol_i | input | 1 | Latched polarity flag |
| ovr_i | input | 1 | Latched overrange flag |
| chip_en_i | input | 1 | Direct-mode chip enable, active high |
| lo_en_i | input | 1 | Direct-mode low byte enable |
| hi_en_i | input | 1 | Direct-mode high byte enable |
| send_i | input | 1 | Transmitter request for the next byte |
| take_i | input | 1 | Transmitter acknowledge of the presented byte |
| data_o | output | BUS_W | Byte output |
| bus_drive_o | output | 1 | Direct-mode bus drive enable |
| hs_valid_o | output | 1 | Handshake byte presented |
| hs_busy_o | output | 1 | Handshake transfer active |

## Verification
A wrong handshake state shows up at the ports in the first cycle after it occurs. A byte may appear without a send request, a byte may be dropped after the take strobe, or `hs_busy_o` may fail to clear one edge after the high byte is taken. A corrupted snapshot only shows when the byte that carries the bad bits is presented, which can be several handshake steps after the result inputs moved. The bench therefore changes the result inputs while each byte is held. A missed or extra start from the mode edge detector shows one edge after the trigger, through `hs_busy_o`.

// File: rtl/adc_byte_pkg.sv
package adc_byte_pkg;
  typedef enum logic [2:0] {
    HS_IDLE    = 3'd0,
    HS_WAIT_LO = 3'd1,
    HS_SHOW_LO = 3'd2,
    HS_WAIT_HI = 3'd3,
    HS_SHOW_HI = 3'd4
  } hs_state_e;
endpackage

// File: rtl/adc_byte_pack.sv
// Splits a result into low and high bus bytes. Requires BUS_W < MAG_W <= 2*BUS_W-2.
module adc_byte_pack #(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8
) (
  input  logic [MAG_W-1:0] mag_i,
  input  logic             pol_i,
  input  logic             ovr_i,
  output logic [BUS_W-1:0] lo_o,
  output logic [BUS_W-1:0] hi_o
);
  localparam int HI_MAG = MAG_W - BUS_W;
  localparam int PAD    = BUS_W - HI_MAG - 2;

  assign lo_o = mag_i[BUS_W-1:0];

  generate
    if (PAD > 0) begin : g_pad
      assign hi_o = {{PAD{1'b0}}, pol_i, ovr_i, mag_i[MAG_W-1:BUS_W]};
    end else begin : g_nopad
      assign hi_o = {pol_i, ovr_i, mag_i[MAG_W-1:BUS_W]};
    end
  endgenerate
endmodule

// File: rtl/adc_mode_ctl.sv
// Turns the mode input and end-of-conversion strobe into a single start pulse.
module adc_mode_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic eoc_i,
  input  logic busy_i,
  output logic start_o
);
  logic mode_q;
  logic mode_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else         mode_q <= mode_i;
  end

  assign mode_rise = mode_i & ~mode_q;
  // triggers while busy are dropped, not queued
  assign start_o   = ~busy_i & (mode_rise | (mode_i & eoc_i));
endmodule

// File: rtl/adc_hs_fsm.sv
module adc_hs_fsm
  import adc_byte_pkg::*;
#(
  parameter int MAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             send_i,
  input  logic             take_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             pol_i,
  input  logic             ovr_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             sel_hi_o,
  output logic [MAG_W-1:0] snap_mag_o,
  output logic             snap_pol_o,
  output logic             snap_ovr_o
);
  localparam int SNAP_W = MAG_W + 2;

  hs_state_e         state_q, state_d;
  logic [SNAP_W-1:0] snap_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:    if (start_i) state_d = HS_WAIT_LO;
      HS_WAIT_LO: if (send_i)  state_d = HS_SHOW_LO;
      HS_SHOW_LO: if (take_i)  state_d = HS_WAIT_HI;
      HS_WAIT_HI: if (send_i)  state_d = HS_SHOW_HI;
      HS_SHOW_HI: if (take_i)  state_d = HS_IDLE;
      default:                 state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      snap_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == HS_IDLE && start_i) snap_q <= {pol_i, ovr_i, mag_i};
    end
  end

  assign busy_o     = (state_q != HS_IDLE);
  assign valid_o    = (state_q == HS_SHOW_LO) || (state_q == HS_SHOW_HI);
  assign sel_hi_o   = (state_q == HS_WAIT_HI) || (state_q == HS_SHOW_HI);
  assign snap_mag_o = snap_q[MAG_W-1:0];
  assign snap_ovr_o = snap_q[MAG_W];
  assign snap_pol_o = snap_q[MAG_W+1];

  // R7: a byte only appears after a sampled send request
  a_r7_valid_after_send: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(send_i));

  // R8: presented byte held until taken
  a_r8_hold_until_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !take_i) |=> (valid_o && $stable(sel_hi_o) && $stable(snap_q)));

  // R9: high byte taken ends the transfer
  a_r9_done_after_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sel_hi_o && take_i) |=> !busy_o);

  // R11: snapshot frozen during a transfer
  a_r11_snap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(snap_q));
endmodule

// File: rtl/adc_bus_mux.sv
module adc_bus_mux #(
  parameter int BUS_W = 8
) (
  input  logic             busy_i,
  input  logic             hs_valid_i,
  input  logic             hs_sel_hi_i,
  input  logic             chip_en_i,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  input  logic [BUS_W-1:0] live_lo_i,
  input  logic [BUS_W-1:0] live_hi_i,
  input  logic [BUS_W-1:0] snap_lo_i,
  input  logic [BUS_W-1:0] snap_hi_i,
  output logic [BUS_W-1:0] data_o,
  output logic             drive_o
);
  always_comb begin
    drive_o = ~busy_i & chip_en_i & (lo_en_i | hi_en_i);
    data_o  = '0;
    if (hs_valid_i)   data_o = hs_sel_hi_i ? snap_hi_i : snap_lo_i;
    else if (drive_o) data_o = lo_en_i ? live_lo_i : live_hi_i;  // low byte has priority
  end
endmodule

// File: rtl/adc_byte_out.sv
module adc_byte_out #(
  parameter int MAG_W = 12,
  parameter int BUS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             eoc_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             pol_i,
  input  logic             ovr_i,
  input  logic             chip_en_i,
  input  logic             lo_en_i,
  input  logic             hi_en_i,
  input  logic             send_i,
  input  logic             take_i,
  output logic [BUS_W-1:0] data_o,
  output logic             bus_drive_o,
  output logic             hs_valid_o,
  output logic             hs_busy_o
);
  logic             start;
  logic             sel_hi;
  logic [MAG_W-1:0] snap_mag;
  logic             snap_pol, snap_ovr;
  logic [BUS_W-1:0] live_lo, live_hi, snap_lo, snap_hi;

  adc_mode_ctl u_mode_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .eoc_i  (eoc_i),
    .busy_i (hs_busy_o),
    .start_o(start)
  );

  adc_hs_fsm #(.MAG_W(MAG_W)) u_hs_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .send_i    (send_i),
    .take_i    (take_i),
    .mag_i     (mag_i),
    .pol_i     (pol_i),
    .ovr_i     (ovr_i),
    .busy_o    (hs_busy_o),
    .valid_o   (hs_valid_o),
    .sel_hi_o  (sel_hi),
    .snap_mag_o(snap_mag),
    .snap_pol_o(snap_pol),
    .snap_ovr_o(snap_ovr)
  );

  adc_byte_pack #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_pack_live (
    .mag_i(mag_i), .pol_i(pol_i), .ovr_i(ovr_i), .lo_o(live_lo), .hi_o(live_hi)
  );

  adc_byte_pack #(.MAG_W(MAG_W), .BUS_W(BUS_W)) u_pack_snap (
    .mag_i(snap_mag), .pol_i(snap_pol), .ovr_i(snap_ovr), .lo_o(snap_lo), .hi_o(snap_hi)
  );

  adc_bus_mux #(.BUS_W(BUS_W)) u_bus_mux (
    .busy_i     (hs_busy_o),
    .hs_valid_i (hs_valid_o),
    .hs_sel_hi_i(sel_hi),
    .chip_en_i  (chip_en_i),
    .lo_en_i    (lo_en_i),
    .hi_en_i    (hi_en_i),
    .live_lo_i  (live_lo),
    .live_hi_i  (live_hi),
    .snap_lo_i  (snap_lo),
    .snap_hi_i  (snap_hi),
    .data_o     (data_o),
    .drive_o    (bus_drive_o)
  );

  // R6: mode edge while idle starts a transfer
  a_r6_mode_edge_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mode_i) && !hs_busy_o) |=> hs_busy_o);

  // R10: end of conversion with mode held high starts a transfer
  a_r10_eoc_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && eoc_i && !hs_busy_o) |=> hs_busy_o);

  // R5: no transfer appears without a trigger
  a_r5_no_spurious_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hs_busy_o && !mode_i) |=> !hs_busy_o);
endmodule

// File: tb/adc_byte_out_bench.sv
`timescale 1ns/1ps
module adc_byte_out_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mode_i, eoc_i, pol_i, ovr_i;
  logic [11:0] mag_i;
  logic        chip_en_i, lo_en_i, hi_en_i, send_i, take_i;
  logic [7:0]  data_o;
  logic        bus_drive_o, hs_valid_o, hs_busy_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  adc_byte_out u_adc_byte_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .eoc_i(eoc_i),
    .mag_i(mag_i), .pol_i(pol_i), .ovr_i(ovr_i),
    .chip_en_i(chip_en_i), .lo_en_i(lo_en_i), .hi_en_i(hi_en_i),
    .send_i(send_i), .take_i(take_i),
    .data_o(data_o), .bus_drive_o(bus_drive_o),
    .hs_valid_o(hs_valid_o), .hs_busy_o(hs_busy_o)
  );

  function automatic logic [7:0] exp_lo(input logic [11:0] m);
    return m[7:0];
  endfunction

  function automatic logic [7:0] exp_hi(input logic [11:0] m, input logic p, input logic o);
    return {2'b00, p, o, m[11:8]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs change just after a falling edge; one step spans one rising edge
  task automatic step;
    @(negedge clk_i);
  endtask

  task automatic start_pulse;
    mode_i = 1'b1;
    step();
    mode_i = 1'b0;
    chk("R6 busy after mode edge", hs_busy_o, 1);
  endtask

  // expects the block in the wait-for-low-byte state
  task automatic run_xfer(input logic [7:0] lo, input logic [7:0] hi, input int gap);
    chk("R7 no byte before send", hs_valid_o, 0);
    chip_en_i = 1'b1; lo_en_i = 1'b1; #1;
    chk("R13 direct read blocked", bus_drive_o, 0);
    chip_en_i = 1'b0; lo_en_i = 1'b0;
    for (int i = 0; i < gap; i++) begin
      step();
      chk("R7 waiting without send", hs_valid_o, 0);
    end
    send_i = 1'b1; #1;
    chk("R7 not same cycle as send", hs_valid_o, 0);
    step();
    send_i = 1'b0;
    chk("R8 low byte valid", hs_valid_o, 1);
    chk("R8 low byte value", data_o, lo);
    mag_i = ~mag_i; pol_i = ~pol_i; ovr_i = ~ovr_i;
    step(); step();
    chk("R8 low byte held", hs_valid_o, 1);
    chk("R11 low byte unaffected", data_o, lo);
    take_i = 1'b1;
    step();
    take_i = 1'b0;
    chk("R8 advance after take", hs_valid_o, 0);
    chk("R8 still busy", hs_busy_o, 1);
    send_i = 1'b1;
    step();
    send_i = 1'b0;
    chk("R8 high byte valid", hs_valid_o, 1);
    mag_i = mag_i + 12'd1; pol_i = ~pol_i; #1;
    chk("R11 high byte value", data_o, hi);
    step();
    chk("R8 high byte held", data_o, hi);
    take_i = 1'b1;
    step();
    take_i = 1'b0;
    chk("R9 idle after high byte", hs_busy_o, 0);
    chk("R9 no byte after end", hs_valid_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] m;
    logic        p, o;
    rst_ni = 1'b0; mode_i = 0; eoc_i = 0; mag_i = 12'h5A3; pol_i = 1; ovr_i = 1;
    chip_en_i = 0; lo_en_i = 0; hi_en_i = 0; send_i = 0; take_i = 0;
    repeat (3) step();
    chk("R1 busy reset", hs_busy_o, 0);
    chk("R1 valid reset", hs_valid_o, 0);
    chk("R1 drive reset", bus_drive_o, 0);
    chk("R1 data reset", data_o, 0);
    rst_ni = 1'b1;
    step();

    // direct mode sweep over every magnitude
    for (int k = 0; k < 4096; k++) begin
      m = k[11:0]; p = m[0] ^ m[5]; o = m[1] ^ m[9];
      mag_i = m; pol_i = p; ovr_i = o;
      chip_en_i = 1; lo_en_i = 1; hi_en_i = 0; #1;
      chk("R2 low byte", data_o, exp_lo(m));
      chk("R2 drive", bus_drive_o, 1);
      lo_en_i = 0; hi_en_i = 1; #1;
      chk("R3 high byte", data_o, exp_hi(m, p, o));
      lo_en_i = 1; #1;
      chk("R3 low priority", data_o, exp_lo(m));
      chip_en_i = 0; #1;
      chk("R4 chip disabled drive", bus_drive_o, 0);
      chk("R4 chip disabled data", data_o, 0);
      chip_en_i = 1; lo_en_i = 0; hi_en_i = 0; #1;
      chk("R4 no byte enable", {bus_drive_o, data_o}, 0);
      chip_en_i = 0;
    end

    // send/take/eoc in direct mode do nothing
    step();
    for (int k = 0; k < 8; k++) begin
      send_i = k[0]; take_i = k[1]; eoc_i = k[2];
      step();
      chk("R5 stays direct", hs_busy_o, 0);
      chk("R5 no byte", hs_valid_o, 0);
      chk("R10 eoc with mode low", hs_busy_o, 0);
    end
    send_i = 0; take_i = 0; eoc_i = 0;

    // one-shot transfers across patterns and send delays
    for (int k = 0; k < 12; k++) begin
      m = 12'((k * 1453 + 77) % 4096); p = k[0]; o = k[1];
      mag_i = m; pol_i = p; ovr_i = o;
      start_pulse();
      run_xfer(exp_lo(m), exp_hi(m, p, o), k % 3);
      step();
      chk("R9 stays idle with mode low", hs_busy_o, 0);
    end

    // triggers during a transfer are ignored
    m = 12'hC3E; p = 0; o = 1;
    mag_i = m; pol_i = p; ovr_i = o;
    start_pulse();
    mode_i = 1; step(); mode_i = 0;
    eoc_i = 1; step(); eoc_i = 0;
    mag_i = m; pol_i = p; ovr_i = o;
    run_xfer(exp_lo(m), exp_hi(m, p, o), 0);
    step(); step();
    chk("R12 no queued transfer", hs_busy_o, 0);

    // mode held high: first edge, then one transfer per eoc
    m = 12'h1F0; p = 1; o = 0;
    mag_i = m; pol_i = p; ovr_i = o;
    mode_i = 1;
    step();
    chk("R6 rise while held", hs_busy_o, 1);
    run_xfer(exp_lo(m), exp_hi(m, p, o), 1);
    step(); step();
    chk("R10 idle without eoc", hs_busy_o, 0);
    for (int k = 0; k < 4; k++) begin
      m = 12'(k * 911 + 5); p = k[1]; o = k[0];
      mag_i = m; pol_i = p; ovr_i = o;
      eoc_i = 1;
      step();
      eoc_i = 0;
      chk("R10 eoc starts transfer", hs_busy_o, 1);
      step();
      eoc_i = 1; step(); eoc_i = 0;
      mag_i = m; pol_i = p; ovr_i = o;
      run_xfer(exp_lo(m), exp_hi(m, p, o), k % 2);
      step();
      chk("R12 eoc during transfer ignored", hs_busy_o, 0);
    end
    mode_i = 0;
    step();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule